// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block is the reset controller of a small system, clocked by the fast oscillator clock. It collects every reset request the system can raise: power-on, low supply, an external pin pulled low, the watchdog, an illegal opcode, an illegal address and a USB bus reset. It turns each request into a timed sequence. The sequence pulls an open-drain reset pad low, then holds an internal reset a little longer. A status register records which sources caused the last reset.

A power-on or low-supply request first waits through a long stabilisation count with the pad held low. Every other source starts at the shorter pad-drive phase. The block also holds a configuration byte that can be written once after each reset. That byte selects whether a USB bus reset becomes an interrupt, whether the low-supply detector is ignored, and whether stop mode recovers in the short or the long delay. The block also produces the bus-clock enable at one quarter of the oscillator rate. That enable stays quiet during the stabilisation wait and while the system is stopped.

The detectors are plain synchronous inputs. The pad level comes back through `pin_n_i`, so the block sees its own drive on that input.

Top module: `rst_seq_ctl`

## Requirements
- R1: While `por_i` is high, and for 4096 cycles after it falls, the pad drive and internal reset are high. The status reads 0x80 and the configuration reads 0x00. A later power-on always returns the status to exactly 0x80.
- R2: After the stabilisation wait, the pad is driven for 32 cycles. The internal reset alone then stays high for 32 more cycles before the block returns to idle. The pad is never driven without the internal reset.
- R3: A watchdog, illegal-opcode or illegal-address pulse taken while idle starts the pad-drive phase on the next cycle. It replaces the status with that source's bit only.
- R4: The status bit map is: bit 7 power-on, bit 6 pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 USB, bit 1 low supply. Bit 0 always reads 0.
- R5: A low-supply request (configuration bit 4 clear) runs the same 4096 + 32 + 32 sequence as power-on. It sets status bit 1 and clears configuration bits 5:0.
- R6: A pin reset is recognised only after 67 consecutive sampled cycles of the pad low while the block is not driving it. It then sets status bit 6 and starts the pad-drive phase. 66 cycles have no effect.
- R7: A source arriving while a sequence runs restarts the sequence from that source's first phase. It ORs its bit into the status.
- R8: Only the first configuration write after a completed reset is taken. Later writes, and writes during a reset, are ignored. Bits 7:6 read 0.
- R9: A reset other than power-on or low supply clears configuration bits 3:0, keeps bits 5:4, and re-arms the one write.
- R10: With configuration bit 5 set, a USB bus reset gives a one-cycle `usb_irq_o` on the next cycle and no reset. With bit 5 clear, it resets and sets status bit 2.
- R11: With configuration bit 4 set, `lvi_i` has no effect.
- R12: A stop request while idle raises `stop_o` and halts the bus enable. After a wake pulse, `stop_o` stays high for 4096 cycles, or 2048 with configuration bit 3 set.
- R13: Outside the stabilisation wait and stop, `bus_en_o` is high for one cycle in every four. It is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on detector, synchronous active-high reset of the block |
| lvi_i | input | 1 | Low-supply detector |
| pin_n_i | input | 1 | Sampled level of the reset pad (low = asserted) |
| cop_i | input | 1 | Watchdog reset request |
| ilop_i | input | 1 | Illegal-opcode reset request |
| ilad_i | input | 1 | Illegal-address reset request |
| usb_rst_i | input | 1 | USB bus reset detected |
| stop_req_i | input | 1 | Enter stop mode |
| wake_i | input | 1 | Wake-up event while stopped |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| rst_pin_drive_o | output | 1 | Pull the open-drain reset pad low |
| int_rst_o | output | 1 | Internal reset |
| rst_stat_o | output | 8 | Reset cause register |
| cfg_o | output | 8 | Configuration register |
| usb_irq_o | output | 1 | USB reset routed as interrupt |
| stop_o | output | 1 | Clocks stopped (including recovery) |
| bus_en_o | output | 1 | Bus clock enable, one cycle in four |

## Verification
The checker holds cycle-level invariants on every cycle: the pad is only driven inside an internal reset, status bit 0 and configuration bits 7:6 stay zero, and the power-on bit never rises outside power-on. It also checks that the bus enable never fires twice in a row or while stopped, that stop is only entered on request, and that a USB interrupt follows a USB reset with routing enabled. Phase lengths, restart on a late source, the 66/67-cycle pin threshold, the write-once rule with its re-arming, and the two stop-recovery lengths depend on long windows and history. Only the bench scenarios, with the reference model compared on every clock, can show those.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PWRUP = 2'd1,
    PH_DRIVE = 2'd2,
    PH_HOLD  = 2'd3
  } rsq_phase_e;

  // status bit positions
  localparam int ST_POR  = 7;
  localparam int ST_PIN  = 6;
  localparam int ST_COP  = 5;
  localparam int ST_ILOP = 4;
  localparam int ST_ILAD = 3;
  localparam int ST_USB  = 2;
  localparam int ST_LVI  = 1;

  // configuration bit positions
  localparam int CF_USBIRQ   = 5;
  localparam int CF_LVIOFF   = 4;
  localparam int CF_SHORTREC = 3;
endpackage

// File: rtl/rsq_sequencer.sv
module rsq_sequencer import rsq_pkg::*; #(
  parameter int PWRUP_CYC = 4096,
  parameter int DRIVE_CYC = 32,
  parameter int HOLD_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_long,
  input  logic       start_short,
  output rsq_phase_e phase_o
);
  localparam int MAX_A = (PWRUP_CYC > DRIVE_CYC) ? PWRUP_CYC : DRIVE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  rsq_phase_e    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start_long) begin
      phase <= PH_PWRUP;
      cnt   <= '0;
    end else if (start_short) begin
      phase <= PH_DRIVE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_PWRUP: if (cnt == CW'(PWRUP_CYC - 1)) begin
                    phase <= PH_DRIVE; cnt <= '0;
                  end else cnt <= cnt + 1'b1;
        PH_DRIVE: if (cnt == CW'(DRIVE_CYC - 1)) begin
                    phase <= PH_HOLD; cnt <= '0;
                  end else cnt <= cnt + 1'b1;
        PH_HOLD:  if (cnt == CW'(HOLD_CYC - 1)) begin
                    phase <= PH_IDLE; cnt <= '0;
                  end else cnt <= cnt + 1'b1;
        default:  cnt <= '0;
      endcase
    end
  end

  assign phase_o = phase;
endmodule

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int MIN_CYC = 67
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic self_drive,
  output logic event_o
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] low_cnt;
  logic          sense;

  // low level that the block itself is not causing
  assign sense   = ~pin_n & ~self_drive;
  assign event_o = sense && (low_cnt == CW'(MIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !sense)
      low_cnt <= '0;
    else if (low_cnt != CW'(MIN_CYC))
      low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/rsq_stop_timer.sv
module rsq_stop_timer #(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic wake,
  input  logic short_sel,
  output logic stopped_o
);
  localparam int CW = (LONG_CYC > SHORT_CYC) ? $clog2(LONG_CYC) : $clog2(SHORT_CYC);

  logic          stopped, recovering;
  logic [CW-1:0] rcnt, last;

  assign last = short_sel ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped    <= 1'b0;
      recovering <= 1'b0;
      rcnt       <= '0;
    end else if (!stopped) begin
      if (enter) stopped <= 1'b1;
    end else if (!recovering) begin
      if (wake) begin
        recovering <= 1'b1;
        rcnt       <= '0;
      end
    end else if (rcnt == last) begin
      stopped    <= 1'b0;
      recovering <= 1'b0;
      rcnt       <= '0;
    end else begin
      rcnt <= rcnt + 1'b1;
    end
  end

  assign stopped_o = stopped;
endmodule

// File: rtl/rsq_bus_div.sv
module rsq_bus_div #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic en_o
);
  localparam int DW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      div  <= '0;
      en_o <= 1'b0;
    end else begin
      en_o <= (div == DW'(RATIO - 1));
      div  <= (div == DW'(RATIO - 1)) ? '0 : div + 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_ctl.sv
module rst_seq_ctl import rsq_pkg::*; #(
  parameter int PWRUP_CYC      = 4096,
  parameter int DRIVE_CYC      = 32,
  parameter int HOLD_CYC       = 32,
  parameter int PIN_MIN_CYC    = 67,
  parameter int STOP_LONG_CYC  = 4096,
  parameter int STOP_SHORT_CYC = 2048,
  parameter int BUS_RATIO      = 4
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       lvi_i,
  input  logic       pin_n_i,
  input  logic       cop_i,
  input  logic       ilop_i,
  input  logic       ilad_i,
  input  logic       usb_rst_i,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic       rst_pin_drive_o,
  output logic       int_rst_o,
  output logic [7:0] rst_stat_o,
  output logic [7:0] cfg_o,
  output logic       usb_irq_o,
  output logic       stop_o,
  output logic       bus_en_o
);
  rsq_phase_e phase;
  logic       idle, drive, pin_ev, lvi_ev, usb_ev, int_ev, any_ev, stopped;
  logic [5:0] cfg_q;
  logic       cfg_done;
  logic [7:0] new_bits;
  logic       unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[7:6];

  assign idle   = (phase == PH_IDLE);
  assign drive  = (phase == PH_PWRUP) || (phase == PH_DRIVE);
  assign lvi_ev = lvi_i & ~cfg_q[CF_LVIOFF];
  assign usb_ev = usb_rst_i & ~cfg_q[CF_USBIRQ];
  assign int_ev = cop_i | ilop_i | ilad_i | usb_ev;
  assign any_ev = lvi_ev | int_ev | pin_ev;

  always_comb begin
    new_bits          = '0;
    new_bits[ST_PIN]  = pin_ev;
    new_bits[ST_COP]  = cop_i;
    new_bits[ST_ILOP] = ilop_i;
    new_bits[ST_ILAD] = ilad_i;
    new_bits[ST_USB]  = usb_ev;
    new_bits[ST_LVI]  = lvi_ev;
  end

  rsq_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin (
    .clk(clk), .rst(por_i), .pin_n(pin_n_i), .self_drive(drive), .event_o(pin_ev)
  );

  rsq_sequencer #(.PWRUP_CYC(PWRUP_CYC), .DRIVE_CYC(DRIVE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst(por_i), .start_long(lvi_ev),
    .start_short(int_ev | (pin_ev & idle)), .phase_o(phase)
  );

  rsq_stop_timer #(.LONG_CYC(STOP_LONG_CYC), .SHORT_CYC(STOP_SHORT_CYC)) u_stop (
    .clk(clk), .rst(por_i | any_ev), .enter(stop_req_i & idle), .wake(wake_i),
    .short_sel(cfg_q[CF_SHORTREC]), .stopped_o(stopped)
  );

  rsq_bus_div #(.RATIO(BUS_RATIO)) u_div (
    .clk(clk), .rst(por_i), .hold((phase == PH_PWRUP) | stopped), .en_o(bus_en_o)
  );

  // cause register: a fresh reset replaces, a late one accumulates
  always_ff @(posedge clk) begin
    if (por_i)
      rst_stat_o <= 8'h80;
    else if (any_ev)
      rst_stat_o <= (idle ? 8'h00 : rst_stat_o) | new_bits;
  end

  always_ff @(posedge clk) begin
    if (por_i || lvi_ev) begin
      cfg_q    <= '0;
      cfg_done <= 1'b0;
    end else if (int_ev || (pin_ev && idle)) begin
      cfg_q[3:0] <= '0;
      cfg_done   <= 1'b0;
    end else if (cfg_we_i && !cfg_done && idle && !pin_ev) begin
      cfg_q    <= cfg_wdata_i[5:0];
      cfg_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) usb_irq_o <= 1'b0;
    else       usb_irq_o <= usb_rst_i & cfg_q[CF_USBIRQ];
  end

  assign rst_pin_drive_o = drive;
  assign int_rst_o       = !idle;
  assign cfg_o           = {2'b00, cfg_q};
  assign stop_o          = stopped;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic       clk,
  input logic       por_i,
  input logic       usb_rst_i,
  input logic       stop_req_i,
  input logic       rst_pin_drive_o,
  input logic       int_rst_o,
  input logic [7:0] rst_stat_o,
  input logic [7:0] cfg_o,
  input logic       usb_irq_o,
  input logic       stop_o,
  input logic       bus_en_o
);
  // R2
  drive_in_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    rst_pin_drive_o |-> int_rst_o);
  // R4
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (por_i)
    rst_stat_o[0] == 1'b0);
  // R8
  cfg_top_zero_chk: assert property (@(posedge clk) disable iff (por_i)
    cfg_o[7:6] == 2'b00);
  // R1
  por_bit_no_rise_chk: assert property (@(posedge clk) disable iff (por_i)
    !$rose(rst_stat_o[7]));
  // R10
  usb_irq_cause_chk: assert property (@(posedge clk) disable iff (por_i)
    usb_irq_o |-> ($past(usb_rst_i) && $past(cfg_o[5])));
  // R12
  stop_quiet_bus_chk: assert property (@(posedge clk) disable iff (por_i)
    (stop_o && $past(stop_o)) |-> !bus_en_o);
  // R12
  stop_entry_chk: assert property (@(posedge clk) disable iff (por_i)
    $rose(stop_o) |-> $past(stop_req_i));
  // R13
  bus_gap_chk: assert property (@(posedge clk) disable iff (por_i)
    bus_en_o |=> !bus_en_o);
endmodule

bind rst_seq_ctl rsq_checker u_chk (
  .clk(clk), .por_i(por_i), .usb_rst_i(usb_rst_i), .stop_req_i(stop_req_i),
  .rst_pin_drive_o(rst_pin_drive_o), .int_rst_o(int_rst_o), .rst_stat_o(rst_stat_o),
  .cfg_o(cfg_o), .usb_irq_o(usb_irq_o), .stop_o(stop_o), .bus_en_o(bus_en_o)
);

// File: tb/tb_rst_seq_ctl.sv
`timescale 1ns/1ps
module tb_rst_seq_ctl;
  localparam int PWRUP = 4096, DRV = 32, HLD = 32, PMIN = 67, SLONG = 4096, SSHORT = 2048;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por = 1'b1, lvi = 0, cop = 0, ilop = 0, ilad = 0, usb = 0;
  logic stop_req = 0, wake = 0, cfg_we = 0, ext_low = 0;
  logic [7:0] cfg_wdata = 8'h00;
  logic pin_n, drive, irst, usb_irq, stop, bus_en;
  logic [7:0] stat, cfg;

  assign pin_n = !(ext_low || drive);

  rst_seq_ctl #(.PWRUP_CYC(PWRUP), .DRIVE_CYC(DRV), .HOLD_CYC(HLD), .PIN_MIN_CYC(PMIN),
                .STOP_LONG_CYC(SLONG), .STOP_SHORT_CYC(SSHORT), .BUS_RATIO(4)) dut (
    .clk(clk), .por_i(por), .lvi_i(lvi), .pin_n_i(pin_n), .cop_i(cop), .ilop_i(ilop),
    .ilad_i(ilad), .usb_rst_i(usb), .stop_req_i(stop_req), .wake_i(wake),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .rst_pin_drive_o(drive),
    .int_rst_o(irst), .rst_stat_o(stat), .cfg_o(cfg), .usb_irq_o(usb_irq),
    .stop_o(stop), .bus_en_o(bus_en));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit cmp_on = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // reference model: phase 0 idle, 1 wait, 2 drive, 3 hold; m_left = cycles left in phase
  int m_ph = 1, m_left = PWRUP, m_low = 0, m_rleft = 0, m_div = 0;
  bit m_stop = 0, m_rec = 0, m_bus = 0, m_irq = 0, m_done = 0;
  logic [7:0] m_stat = 8'h80, m_cfg = 8'h00;

  always @(posedge clk) begin
    bit mi, md, smp, pe, le, ue, ie, anye;
    logic [7:0] nb;
    int len;
    mi   = (m_ph == 0);
    md   = (m_ph == 1) || (m_ph == 2);
    smp  = ext_low && !md;
    pe   = smp && (m_low == PMIN - 1);
    le   = lvi && !m_cfg[4];
    ue   = usb && !m_cfg[5];
    ie   = cop || ilop || ilad || ue;
    anye = le || ie || pe;
    nb   = {1'b0, pe, cop, ilop, ilad, ue, le, 1'b0};
    len  = m_cfg[3] ? SSHORT : SLONG;
    if (por) begin
      m_ph = 1; m_left = PWRUP; m_stat = 8'h80; m_cfg = 0; m_done = 0; m_low = 0;
      m_stop = 0; m_rec = 0; m_rleft = 0; m_div = 0; m_bus = 0; m_irq = 0;
    end else begin
      m_irq = usb && m_cfg[5];
      if (m_ph == 1 || m_stop) begin m_div = 0; m_bus = 0; end
      else begin m_bus = (m_div == 3); m_div = (m_div + 1) % 4; end
      if (!smp) m_low = 0; else if (m_low < PMIN) m_low++;
      if (anye) begin m_stop = 0; m_rec = 0; end
      else if (!m_stop) begin if (stop_req && mi) m_stop = 1; end
      else if (!m_rec) begin if (wake) begin m_rec = 1; m_rleft = len; end end
      else begin
        m_rleft--;
        if (m_rleft == 0) begin m_stop = 0; m_rec = 0; end
      end
      if (anye) m_stat = (mi ? 8'h00 : m_stat) | nb;
      if (le) begin m_cfg = 0; m_done = 0; end
      else if (ie || (pe && mi)) begin m_cfg = m_cfg & 8'h30; m_done = 0; end
      else if (!pe && cfg_we && !m_done && mi) begin m_cfg = cfg_wdata & 8'h3F; m_done = 1; end
      if (le) begin m_ph = 1; m_left = PWRUP; end
      else if (ie || (pe && mi)) begin m_ph = 2; m_left = DRV; end
      else if (m_ph != 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_ph == 1) begin m_ph = 2; m_left = DRV; end
          else if (m_ph == 2) begin m_ph = 3; m_left = HLD; end
          else m_ph = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      chk("R2 pad drive", drive, (m_ph == 1 || m_ph == 2));
      chk("R2 internal reset", irst, (m_ph != 0));
      chk("R4 status", stat, m_stat);
      chk("R8 config", cfg, m_cfg);
      chk("R12 stop", stop, m_stop);
      chk("R13 bus enable", bus_en, m_bus);
      chk("R10 usb irq", usb_irq, m_irq);
    end
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      done_run();
    end
  end

  initial begin
    int nb_cnt;
    step(1);
    cmp_on = 1;
    step(4);
    chk("R1 drive in por", drive, 1); chk("R1 rst in por", irst, 1);
    chk("R1 status", stat, 8'h80);    chk("R1 config", cfg, 8'h00);
    por = 0;
    step(PWRUP - 1);
    chk("R1 drive end of wait", drive, 1); chk("R13 bus quiet in wait", bus_en, 0);
    step(1);
    chk("R2 drive phase", drive, 1);
    step(DRV);
    chk("R2 hold no drive", drive, 0); chk("R2 hold rst", irst, 1);
    step(HLD);
    chk("R2 idle", irst, 0);

    cfg_we = 1; cfg_wdata = 8'h08; step(1); cfg_we = 0;
    chk("R8 first write", cfg, 8'h08);
    cfg_we = 1; cfg_wdata = 8'hFF; step(1); cfg_we = 0;
    chk("R8 second write ignored", cfg, 8'h08);

    stop_req = 1; step(1); stop_req = 0;
    chk("R12 stopped", stop, 1);
    step(3); chk("R12 bus halted", bus_en, 0);
    wake = 1; step(1); wake = 0;
    step(SSHORT - 1); chk("R12 short still stopped", stop, 1);
    step(1);          chk("R12 short resumed", stop, 0);

    cop = 1; step(1); cop = 0;
    chk("R3 cop drive", drive, 1); chk("R3 cop status", stat, 8'h20);
    chk("R9 low cfg cleared", cfg, 8'h00);
    step(DRV + HLD); chk("R3 cop done", irst, 0);
    cfg_we = 1; cfg_wdata = 8'h38; step(1); cfg_we = 0;
    chk("R9 write re-armed", cfg, 8'h38);

    lvi = 1; step(1); lvi = 0;
    chk("R11 lvi ignored rst", irst, 0); chk("R11 lvi ignored status", stat, 8'h20);
    usb = 1; step(1); usb = 0;
    chk("R10 irq raised", usb_irq, 1); chk("R10 no reset", irst, 0);
    step(1); chk("R10 irq one cycle", usb_irq, 0);

    ilop = 1; step(1); ilop = 0;
    chk("R3 ilop status", stat, 8'h10); chk("R9 high cfg kept", cfg, 8'h30);
    step(10);
    ilad = 1; step(1); ilad = 0;
    chk("R7 status merged", stat, 8'h18);
    step(DRV - 1); chk("R7 drive restarted", drive, 1);
    step(1); chk("R7 hold after restart", drive, 0); chk("R7 rst in hold", irst, 1);
    cfg_we = 1; cfg_wdata = 8'h3F; step(1); cfg_we = 0;
    step(HLD - 1);
    chk("R7 idle", irst, 0); chk("R8 write in reset ignored", cfg, 8'h30);
    cfg_we = 1; cfg_wdata = 8'h20; step(1); cfg_we = 0;
    chk("R8 write after reset", cfg, 8'h20);

    lvi = 1; step(1); lvi = 0;
    chk("R5 lvi drive", drive, 1); chk("R5 lvi status", stat, 8'h02);
    chk("R5 lvi cfg cleared", cfg, 8'h00);
    step(PWRUP - 1);
    chk("R5 still waiting", drive, 1); chk("R5 bus quiet", bus_en, 0);
    step(1 + DRV + HLD); chk("R5 done", irst, 0);

    ext_low = 1; step(PMIN - 1); ext_low = 0; step(1);
    chk("R6 short pin ignored", irst, 0); chk("R6 short pin status", stat, 8'h02);
    ext_low = 1; step(PMIN);
    chk("R6 pin reset", drive, 1); chk("R6 pin status", stat, 8'h40);
    ext_low = 0;
    step(DRV + HLD); chk("R6 pin done", irst, 0);

    usb = 1; step(1); usb = 0;
    chk("R10 usb reset", drive, 1); chk("R10 usb status", stat, 8'h04);
    step(DRV + HLD);

    nb_cnt = 0;
    for (int i = 0; i < 8; i++) begin step(1); nb_cnt += bus_en; end
    chk("R13 bus rate", nb_cnt, 2);

    por = 1; step(2);
    chk("R1 repeat por status", stat, 8'h80); chk("R1 repeat por cfg", cfg, 8'h00);
    por = 0; step(10);
    done_run();
  end
endmodule